// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps stores that have executed but not yet retired, so the data cache is never written by an instruction that might still be squashed. Each slot records a valid flag, a speculative flag, the store address, the store data and a program-order age. When a store executes, it takes a free slot and is marked speculative. When the core retires stores one at a time, the oldest speculative slot becomes non-speculative. A pipeline flush removes every speculative slot at or after a given age. Non-speculative slots leave for the cache write port one per cycle, oldest first, whenever the cache is ready.

Loads probe the buffer in the same cycle as they probe the cache. If a live slot holds the same address and is older than the load, the block raises a hit and returns that data. The load path then uses the buffer data in place of the cache data. When several slots match, the youngest slot that is still older than the load supplies the data. Lookups and the drain port see the slot state that was registered at the last clock edge. A store accepted in the current cycle is therefore visible one cycle later.

Top module: `ssb_store_buffer`

## Requirements
- R1: After reset every slot is empty. `st_ready` is 1, `wr_valid` is 0, and `ld_hit` is 0 for any lookup.
- R2: A store offered with `st_valid` while `st_ready` is 1 is written into a free slot as live and speculative, with its address, data and age. Loads can see it from the next cycle on.
- R3: `st_ready` is 0 exactly when all DEPTH slots are live. A store offered in that state is dropped and never appears on the load or write ports.
- R4: `cm_valid` makes the live speculative slot with the smallest age non-speculative. When no speculative slot exists, `cm_valid` changes nothing.
- R5: `ab_valid` removes every live speculative slot whose age is greater than or equal to `ab_age`. A store offered in the same cycle with `st_age >= ab_age` is not written.
- R6: `wr_valid` is 1 while a live non-speculative slot exists. `wr_addr` and `wr_data` come from the one with the smallest age, and they stay unchanged until the cycle in which `cache_ready` is 1, when that slot is freed.
- R7: A speculative slot is never presented on the cache write port.
- R8: With `ld_valid` high, `ld_hit` is 1 when some live slot has an address equal to `ld_addr` and an age below `ld_age`. `ld_data` is then taken from the matching slot with the largest age, and this data overrides the cache.
- R9: Slots whose age is equal to or larger than `ld_age` never supply data to that load.
- R10: A slot removed by an abort or freed by a drain no longer forwards data or reaches the write port.
- R11: Ages are compared as unsigned numbers, and a larger value means younger in program order. The caller keeps ages unique among live slots and issues them in increasing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Executed store presented |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_age | input | AGE_W | Store program-order age |
| st_ready | output | 1 | A free slot exists |
| cm_valid | input | 1 | Retire the oldest speculative store |
| ab_valid | input | 1 | Flush request |
| ab_age | input | AGE_W | Oldest age removed by the flush |
| ld_valid | input | 1 | Load lookup presented |
| ld_addr | input | ADDR_W | Load address |
| ld_age | input | AGE_W | Load program-order age |
| ld_hit | output | 1 | Buffer supplies the load data |
| ld_data | output | DATA_W | Forwarded data |
| cache_ready | input | 1 | Cache accepts a write this cycle |
| wr_valid | output | 1 | Cache write request |
| wr_addr | output | ADDR_W | Cache write address |
| wr_data | output | DATA_W | Cache write data |

## Verification
The checker watches several properties on every cycle:
- Occupancy grows by at most one slot per cycle.
- A full buffer gains no slot.
- The write port only ever presents a retired slot, and a stalled write request holds its address and data.
- No speculative slot at or after the flush age survives a flush.
- A hit is raised only for an active lookup.

The bench scenarios are needed to show the behaviour that depends on values:
- Which of several matching stores forwards its data.
- That equal or younger stores are skipped.
- That large ages compare as unsigned values.
- That a refused or flushed store leaves no trace.
- That drains leave the buffer in retirement order.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
   // Selection direction used by the age pickers
   typedef enum logic {
      SSB_PICK_OLDEST   = 1'b0,
      SSB_PICK_YOUNGEST = 1'b1
   } ssb_pick_e;
endpackage

// File: rtl/ssb_free_find.sv
module ssb_free_find #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  busy,
   output logic          any_free,
   output logic [IW-1:0] free_idx
);
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            any_free = 1'b1;
            free_idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/ssb_age_pick.sv
module ssb_age_pick
   import ssb_pkg::*;
#(
   parameter int        N     = 8,
   parameter int        AGE_W = 8,
   parameter ssb_pick_e MODE  = SSB_PICK_OLDEST,
   localparam int       IW    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]            cand,
   input  logic [N-1:0][AGE_W-1:0] ages,
   output logic                    found,
   output logic [IW-1:0]           pick_idx
);
   logic [AGE_W-1:0] best_age;

   generate
      if (MODE == SSB_PICK_OLDEST) begin : g_oldest
         always_comb begin
            found    = 1'b0;
            pick_idx = '0;
            best_age = '0;
            for (int i = 0; i < N; i++) begin
               if (cand[i] && (!found || ages[i] < best_age)) begin
                  found    = 1'b1;
                  pick_idx = IW'(i);
                  best_age = ages[i];
               end
            end
         end
      end else begin : g_youngest
         always_comb begin
            found    = 1'b0;
            pick_idx = '0;
            best_age = '0;
            for (int i = 0; i < N; i++) begin
               if (cand[i] && (!found || ages[i] > best_age)) begin
                  found    = 1'b1;
                  pick_idx = IW'(i);
                  best_age = ages[i];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ssb_entry.sv
module ssb_entry #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int AGE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic [AGE_W-1:0]  fill_age,
   input  logic              retire,
   input  logic              flush,
   input  logic [AGE_W-1:0]  flush_age,
   input  logic              drained,
   output logic              live,
   output logic              spec,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic [AGE_W-1:0]  age
);
   logic killed;
   assign killed = flush && live && spec && (age >= flush_age);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live <= 1'b0;
         spec <= 1'b0;
      end else if (fill) begin
         live <= 1'b1;
         spec <= 1'b1;
      end else begin
         if (retire)
            spec <= 1'b0;
         if (killed || drained)
            live <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill) begin
         addr <= fill_addr;
         data <= fill_data;
         age  <= fill_age;
      end
   end
endmodule

// File: rtl/ssb_store_buffer.sv
module ssb_store_buffer
   import ssb_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int AGE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [AGE_W-1:0]  st_age,
   output logic              st_ready,
   input  logic              cm_valid,
   input  logic              ab_valid,
   input  logic [AGE_W-1:0]  ab_age,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [AGE_W-1:0]  ld_age,
   output logic              ld_hit,
   output logic [DATA_W-1:0] ld_data,
   input  logic              cache_ready,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int IW = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ssb_store_buffer: DEPTH must be at least 2");
      end
      if (AGE_W < 2) begin : g_bad_age
         $error("ssb_store_buffer: AGE_W must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ssb_store_buffer: widths must be positive");
      end
   endgenerate

   logic [DEPTH-1:0]             e_live, e_spec;
   logic [DEPTH-1:0][ADDR_W-1:0] e_addr;
   logic [DEPTH-1:0][DATA_W-1:0] e_data;
   logic [DEPTH-1:0][AGE_W-1:0]  e_age;

   logic          any_free;
   logic [IW-1:0] free_idx;
   logic          st_fire;

   logic          cm_found, dr_found, ld_found;
   logic [IW-1:0] cm_idx, dr_idx, ld_idx;
   logic [DEPTH-1:0] ld_match;

   ssb_free_find #(.N(DEPTH)) u_free (
      .busy     (e_live),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   assign st_ready = any_free;
   assign st_fire  = st_valid && any_free && !(ab_valid && st_age >= ab_age);

   // retire target: oldest speculative slot
   ssb_age_pick #(.N(DEPTH), .AGE_W(AGE_W), .MODE(SSB_PICK_OLDEST)) u_cm_pick (
      .cand     (e_live & e_spec),
      .ages     (e_age),
      .found    (cm_found),
      .pick_idx (cm_idx)
   );

   // drain target: oldest retired slot
   ssb_age_pick #(.N(DEPTH), .AGE_W(AGE_W), .MODE(SSB_PICK_OLDEST)) u_dr_pick (
      .cand     (e_live & ~e_spec),
      .ages     (e_age),
      .found    (dr_found),
      .pick_idx (dr_idx)
   );

   // forwarding: youngest matching store older than the load
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_match
         assign ld_match[g] = ld_valid && e_live[g] &&
                              (e_addr[g] == ld_addr) && (e_age[g] < ld_age);
      end
   endgenerate

   ssb_age_pick #(.N(DEPTH), .AGE_W(AGE_W), .MODE(SSB_PICK_YOUNGEST)) u_ld_pick (
      .cand     (ld_match),
      .ages     (e_age),
      .found    (ld_found),
      .pick_idx (ld_idx)
   );

   assign ld_hit   = ld_found;
   assign ld_data  = e_data[ld_idx];
   assign wr_valid = dr_found;
   assign wr_addr  = e_addr[dr_idx];
   assign wr_data  = e_data[dr_idx];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         ssb_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGE_W(AGE_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill      (st_fire && free_idx == IW'(g)),
            .fill_addr (st_addr),
            .fill_data (st_data),
            .fill_age  (st_age),
            .retire    (cm_valid && cm_found && cm_idx == IW'(g)),
            .flush     (ab_valid),
            .flush_age (ab_age),
            .drained   (dr_found && cache_ready && dr_idx == IW'(g)),
            .live      (e_live[g]),
            .spec      (e_spec[g]),
            .addr      (e_addr[g]),
            .data      (e_data[g]),
            .age       (e_age[g])
         );
      end
   endgenerate
endmodule

// File: rtl/ssb_store_buffer_chk.sv
module ssb_store_buffer_chk #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int AGE_W  = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         st_ready,
   input logic                         ab_valid,
   input logic [AGE_W-1:0]             ab_age,
   input logic                         ld_valid,
   input logic                         ld_hit,
   input logic                         cache_ready,
   input logic                         wr_valid,
   input logic [ADDR_W-1:0]            wr_addr,
   input logic [DATA_W-1:0]            wr_data,
   input logic [DEPTH-1:0]             v_vec,
   input logic [DEPTH-1:0]             s_vec,
   input logic [DEPTH-1:0][AGE_W-1:0]  a_vec
);
   logic             ab_q;
   logic [AGE_W-1:0] ab_age_q;
   logic             young_spec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ab_q     <= 1'b0;
         ab_age_q <= '0;
      end else begin
         ab_q     <= ab_valid;
         ab_age_q <= ab_age;
      end
   end

   always_comb begin
      young_spec = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (v_vec[i] && s_vec[i] && a_vec[i] >= ab_age_q)
            young_spec = 1'b1;
   end

   // R2
   alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(v_vec) <= $countones($past(v_vec)) + 1);

   // R3
   full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_ready |=> $countones(v_vec) <= $countones($past(v_vec)));

   // R7
   no_spec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> |(v_vec & ~s_vec));

   // R6
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !cache_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   // R5
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_q |-> !young_spec);

   // R8
   hit_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hit |-> (ld_valid && |v_vec));
endmodule

bind ssb_store_buffer ssb_store_buffer_chk #(
   .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGE_W(AGE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .st_ready    (st_ready),
   .ab_valid    (ab_valid),
   .ab_age      (ab_age),
   .ld_valid    (ld_valid),
   .ld_hit      (ld_hit),
   .cache_ready (cache_ready),
   .wr_valid    (wr_valid),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .v_vec       (e_live),
   .s_vec       (e_spec),
   .a_vec       (e_age)
);

// File: tb/ssb_store_buffer_tb_top.sv
module ssb_store_buffer_tb_top;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0, cm_valid = 1'b0, ab_valid = 1'b0;
   logic        ld_valid = 1'b0, cache_ready = 1'b0;
   logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
   logic [7:0]  st_age = '0, ab_age = '0, ld_age = '0;
   logic        st_ready, ld_hit, wr_valid;
   logic [31:0] ld_data, wr_addr, wr_data;

   int total = 0;
   int bad   = 0;

   // behavioural model: entries kept in program order
   logic [31:0] q_addr[$];
   logic [31:0] q_data[$];
   int          q_age[$];
   bit          q_spec[$];

   // last observed outputs
   bit          o_ready, o_wr, o_hit;
   logic [31:0] o_wra, o_wrd, o_ldd;

   always #5 clk = ~clk;

   ssb_store_buffer #(.DEPTH(DEPTH), .ADDR_W(32), .DATA_W(32), .AGE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_age(st_age),
      .st_ready(st_ready), .cm_valid(cm_valid), .ab_valid(ab_valid), .ab_age(ab_age),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
      .ld_hit(ld_hit), .ld_data(ld_data), .cache_ready(cache_ready),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare, update model as the edge does
   task automatic step(input bit sv, input logic [31:0] sa, input logic [31:0] sd, input int sag,
                       input bit cm, input bit ab, input int abag,
                       input bit lv, input logic [31:0] la, input int lag, input bit cr);
      bit          e_ready, e_wr, e_hit;
      logic [31:0] e_ldd;
      int          cidx;
      st_valid = sv; st_addr = sa; st_data = sd; st_age = 8'(sag);
      cm_valid = cm; ab_valid = ab; ab_age = 8'(abag);
      ld_valid = lv; ld_addr = la; ld_age = 8'(lag); cache_ready = cr;
      #1;
      o_ready = st_ready; o_wr = wr_valid; o_wra = wr_addr; o_wrd = wr_data;
      o_hit = ld_hit; o_ldd = ld_data;
      e_ready = (q_age.size() < DEPTH);
      e_wr    = (q_age.size() > 0) && !q_spec[0];
      e_hit   = 1'b0;
      e_ldd   = '0;
      if (lv)
         for (int i = q_age.size() - 1; i >= 0; i--)
            if (!e_hit && q_age[i] < lag && q_addr[i] == la) begin
               e_hit = 1'b1;
               e_ldd = q_data[i];
            end
      chk(o_ready == e_ready, "R3 st_ready", 32'(o_ready), 32'(e_ready));
      chk(o_wr == e_wr, "R7 wr_valid", 32'(o_wr), 32'(e_wr));
      if (e_wr) begin
         chk(o_wra == q_addr[0], "R6 wr_addr", o_wra, q_addr[0]);
         chk(o_wrd == q_data[0], "R6 wr_data", o_wrd, q_data[0]);
      end
      chk(o_hit == e_hit, "R8 ld_hit", 32'(o_hit), 32'(e_hit));
      if (e_hit) chk(o_ldd == e_ldd, "R8 ld_data", o_ldd, e_ldd);
      // model update
      cidx = -1;
      for (int i = 0; i < q_age.size(); i++)
         if (cidx < 0 && q_spec[i]) cidx = i;
      if (cm && cidx >= 0) q_spec[cidx] = 1'b0;
      if (ab)
         while (q_age.size() > 0 && q_spec[q_age.size()-1] && q_age[q_age.size()-1] >= abag) begin
            void'(q_age.pop_back()); void'(q_addr.pop_back());
            void'(q_data.pop_back()); void'(q_spec.pop_back());
         end
      if (e_wr && cr) begin
         void'(q_age.pop_front()); void'(q_addr.pop_front());
         void'(q_data.pop_front()); void'(q_spec.pop_front());
      end
      if (sv && e_ready && !(ab && sag >= abag)) begin
         q_age.push_back(sag); q_addr.push_back(sa);
         q_data.push_back(sd); q_spec.push_back(1'b1);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_st(input logic [31:0] a, input logic [31:0] d, input int ag);
      step(1, a, d, ag, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic do_ld(input logic [31:0] a, input int ag);
      step(0, 0, 0, 0, 0, 0, 0, 1, a, ag, 0);
   endtask
   task automatic do_cm();
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic do_ab(input int ag);
      step(0, 0, 0, 0, 0, 1, ag, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int next_age;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      do_ld(32'h100, 9);
      chk(o_ready == 1, "R1 ready after reset", 32'(o_ready), 1);
      chk(o_wr == 0, "R1 no write after reset", 32'(o_wr), 0);
      chk(o_hit == 0, "R1 no hit after reset", 32'(o_hit), 0);
      // R2 / R8 / R9 forwarding choice
      do_st(32'h100, 32'hA1, 1);
      do_st(32'h100, 32'hA2, 3);
      do_ld(32'h100, 2);
      chk(o_hit && o_ldd == 32'hA1, "R9 younger store skipped", o_ldd, 32'hA1);
      do_ld(32'h100, 5);
      chk(o_hit && o_ldd == 32'hA2, "R2 R8 youngest older store", o_ldd, 32'hA2);
      do_ld(32'h100, 1);
      chk(o_hit == 0, "R9 equal age ignored", 32'(o_hit), 0);
      chk(o_wr == 0, "R7 speculative not written", 32'(o_wr), 0);
      // R4 retire oldest
      do_cm();
      do_ld(32'h100, 5);
      chk(o_wr && o_wra == 32'h100 && o_wrd == 32'hA1, "R4 oldest retired", o_wrd, 32'hA1);
      // R5 / R10 flush
      do_ab(3);
      do_ld(32'h100, 5);
      chk(o_hit && o_ldd == 32'hA1, "R10 flushed store not forwarded", o_ldd, 32'hA1);
      // R6 drain
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      do_ld(32'h100, 5);
      chk(o_hit == 0 && o_wr == 0, "R6 drained slot gone", 32'(o_hit), 0);
      // R4 retire with nothing speculative
      do_cm();
      do_st(32'h200, 32'hB1, 4);
      do_ld(32'h200, 9);
      chk(o_wr == 0, "R4 empty retire no effect", 32'(o_wr), 0);
      // R5 flush with same-cycle store
      step(1, 32'h300, 32'hB2, 5, 0, 1, 4, 0, 0, 0, 0);
      do_ld(32'h300, 9);
      chk(o_hit == 0, "R5 same-cycle store dropped", 32'(o_hit), 0);
      do_ld(32'h200, 9);
      chk(o_hit == 0, "R10 flushed store gone", 32'(o_hit), 0);
      // R11 unsigned ages
      do_st(32'h400, 32'hC1, 10);
      do_st(32'h400, 32'hC2, 200);
      do_ld(32'h400, 250);
      chk(o_ldd == 32'hC2, "R11 large age is younger", o_ldd, 32'hC2);
      do_ld(32'h400, 100);
      chk(o_ldd == 32'hC1, "R11 mid age load", o_ldd, 32'hC1);
      do_ab(10);
      // R3 full
      for (int i = 0; i < DEPTH; i++) do_st(32'h500 + 32'(4 * i), 32'hD0 + 32'(i), 20 + i);
      do_st(32'h600, 32'hEE, 28);
      chk(o_ready == 0, "R3 full refuses", 32'(o_ready), 0);
      do_ld(32'h600, 99);
      chk(o_hit == 0, "R3 refused store absent", 32'(o_hit), 0);
      for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
      // random traffic against the model
      next_age = 30;
      for (int c = 0; c < 3000; c++) begin
         bit sv, cm, ab, lv, cr;
         int abag;
         if (q_age.size() == 0 && next_age > 200) next_age = 1;
         sv = ($urandom % 2 == 0) && next_age < 240;
         cm = ($urandom % 3 == 0);
         ab = !cm && ($urandom % 11 == 0);
         abag = next_age;
         if (ab)
            for (int i = 0; i < q_age.size(); i++)
               if (q_spec[i] && abag == next_age && $urandom % 2 == 0) abag = q_age[i];
         lv = ($urandom % 2 == 0);
         cr = ($urandom % 3 != 0);
         step(sv, 32'($urandom % 4) * 4, $urandom, next_age, cm, ab, abag,
              lv, 32'($urandom % 4) * 4, $urandom % (next_age + 2), cr);
         if (sv && !(ab && next_age >= abag)) next_age++;
         if (ab && abag < next_age) next_age = abag;
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule